// File: doc/BRIEF.md
# Bidirectional Long Logical Shifter

This block performs a multi-bit logical shift on the 32-bit long word held in a 36-bit accumulator, whose top 4 bits form an extension field. One operand supplies the value to shift. The other is a 16-bit source word whose low 5 bits give the count. A select input says whether the source is an immediate or a register value. An immediate count always shifts right. A register count whose bit 15 is set is treated as negative, and it shifts left by its magnitude.

The incoming extension field takes no part in the operation. The result is zero-extended from bit 31, so the extension field of every result is zero. Two condition flags come with the result: negative, taken from bit 31, and zero, set for an all-zero long word. The shift network is combinational. Its outputs are captured in a register on every cycle in which the input strobe is high. A synchronous active-high reset clears the register.

Top module: `lsh_long_shifter`

## Requirements
- R1: When `src_is_imm` is 1, the long word shifts right by `src_in[4:0]` (0 to 31), whatever the value of `src_in[15]`.
- R2: When `src_is_imm` is 0 and `src_in[15]` is 0, the long word shifts right by `src_in[4:0]`; bits 14 to 5 have no effect. Example: `F_F123_3456` with count 16 gives `0_0000_F123`.
- R3: When `src_is_imm` is 0 and `src_in[15]` is 1, the long word shifts left by the low 5 bits of the 16-bit two's-complement negation of `src_in`. Counts of -32 and `16'h8000` therefore shift by 0.
- R4: Both directions are logical. Bit positions vacated by the shift are filled with zeros.
- R5: Bits 35 to 32 of `acc_in` have no effect, and bits 35 to 32 of `acc_out` are always 0.
- R6: A count that works out to zero returns bits 31 to 0 of `acc_in` unchanged.
- R7: `flag_n` equals bit 31 of the registered result.
- R8: `flag_z` is 1 exactly when bits 31 to 0 of the registered result are all zero.
- R9: The result and flags appear on the clock edge at which `in_valid` is 1, and `out_valid` is 1 in the following cycle. While `in_valid` is 0, `out_valid` is 0 and `acc_out`, `flag_n` and `flag_z` keep their values.
- R10: A cycle with `rst` at 1 clears `acc_out`, `flag_n`, `flag_z` and `out_valid` to 0, even when `in_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Capture strobe for the operands |
| acc_in | input | 36 | Accumulator operand: extension field in bits 35 to 32, long word in bits 31 to 0 |
| src_in | input | 16 | Count source: bits 4 to 0 give the count, bit 15 is the sign of a register count |
| src_is_imm | input | 1 | 1 selects an immediate count, 0 selects a register count |
| out_valid | output | 1 | A result was captured on the last edge |
| acc_out | output | 36 | Shifted accumulator, with the extension field cleared |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench targets the following corner cases and the failure each one exposes:

- **Count of -32 and `16'h8000`.** A design that takes the magnitude from the whole word would shift by 32 or more and return zero instead of the operand.
- **Immediate with bit 15 set.** A design that checks the sign before it checks the immediate select would turn this right shift into a left shift.
- **Register counts with junk in bits 14 to 5.** A design that decodes more than five bits would compute the wrong shift.
- **Nonzero incoming extension field.** A design that shifts all 36 bits would move ones into the long word or leave them in the top nibble.
- **Flags at the edges.** A left shift that drives a one into bit 31 must set negative, and a shift that pushes every one out must set zero.
- **Idle and reset cycles.** These show whether the register holds its value while idle and clears while the strobe is high during reset.

// File: rtl/lsh_pkg.sv
package lsh_pkg;

    localparam int LONG_W = 32;
    localparam int EXT_W  = 4;
    localparam int ACC_W  = LONG_W + EXT_W;
    localparam int SRC_W  = 16;
    localparam int CNT_W  = $clog2(LONG_W);

    typedef enum logic {
        SH_RIGHT = 1'b0,
        SH_LEFT  = 1'b1
    } shift_dir_e;

    typedef struct packed {
        shift_dir_e             dir;
        logic [CNT_W-1:0]       amt;
    } shift_ctl_t;

    typedef struct packed {
        logic [ACC_W-1:0]       acc;
        logic                   neg;
        logic                   zero;
    } shift_res_t;

    function automatic logic [CNT_W-1:0] negate_count(input logic [CNT_W-1:0] c);
        return CNT_W'(~c) + CNT_W'(1);
    endfunction

endpackage

// File: rtl/lsh_count_decode.sv
module lsh_count_decode
    import lsh_pkg::*;
#(
    parameter int SW = SRC_W,
    parameter int CW = CNT_W
) (
    input  logic [SW-1:0] src,
    input  logic          is_imm,
    output shift_ctl_t    ctl
);
    logic sign_bit;
    logic unused_mid;

    assign sign_bit   = src[SW-1];
    assign unused_mid = ^src[SW-2:CW];

    always_comb begin
        if (is_imm || !sign_bit) begin
            ctl.dir = SH_RIGHT;
            ctl.amt = src[CW-1:0];
        end else begin
            ctl.dir = SH_LEFT;
            ctl.amt = negate_count(src[CW-1:0]);
        end
    end
endmodule

// File: rtl/lsh_barrel.sv
module lsh_barrel
    import lsh_pkg::*;
#(
    parameter int W  = LONG_W,
    parameter int CW = CNT_W
) (
    input  logic [W-1:0] din,
    input  shift_ctl_t   ctl,
    output logic [W-1:0] dout
);
    logic [W-1:0] rev_in;
    logic [W-1:0] pre;
    logic [W-1:0] rev_out;
    logic [W-1:0] stg [CW+1];

    for (genvar b = 0; b < W; b++) begin : g_rev
        assign rev_in[b]  = din[W-1-b];
        assign rev_out[b] = stg[CW][W-1-b];
    end

    assign pre    = (ctl.dir == SH_LEFT) ? rev_in : din;
    assign stg[0] = pre;

    for (genvar s = 0; s < CW; s++) begin : g_stage
        assign stg[s+1] = ctl.amt[s] ? (stg[s] >> (2**s)) : stg[s];
    end

    assign dout = (ctl.dir == SH_LEFT) ? rev_out : stg[CW];
endmodule

// File: rtl/lsh_flag_gen.sv
module lsh_flag_gen
    import lsh_pkg::*;
#(
    parameter int LW = LONG_W,
    parameter int EW = EXT_W
) (
    input  logic [LW-1:0]    long_res,
    output logic [LW+EW-1:0] acc_res,
    output logic             neg,
    output logic             zero
);
    assign acc_res = {{EW{1'b0}}, long_res};
    assign neg     = long_res[LW-1];
    assign zero    = (long_res == '0);
endmodule

// File: rtl/lsh_long_shifter.sv
module lsh_long_shifter
    import lsh_pkg::*;
#(
    parameter int LW = LONG_W,
    parameter int EW = EXT_W,
    parameter int SW = SRC_W,
    parameter int CW = CNT_W,
    localparam int AW = LW + EW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [AW-1:0] acc_in,
    input  logic [SW-1:0] src_in,
    input  logic          src_is_imm,
    output logic          out_valid,
    output logic [AW-1:0] acc_out,
    output logic          flag_n,
    output logic          flag_z
);
    shift_ctl_t    ctl;
    logic [LW-1:0] shifted;
    logic [AW-1:0] acc_next;
    logic          n_next;
    logic          z_next;
    logic          unused_ext;

    assign unused_ext = ^acc_in[AW-1:LW];

    lsh_count_decode #(.SW(SW), .CW(CW)) u_decode (
        .src    (src_in),
        .is_imm (src_is_imm),
        .ctl    (ctl)
    );

    lsh_barrel #(.W(LW), .CW(CW)) u_barrel (
        .din  (acc_in[LW-1:0]),
        .ctl  (ctl),
        .dout (shifted)
    );

    lsh_flag_gen #(.LW(LW), .EW(EW)) u_flags (
        .long_res (shifted),
        .acc_res  (acc_next),
        .neg      (n_next),
        .zero     (z_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            acc_out   <= '0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_out <= acc_next;
                flag_n  <= n_next;
                flag_z  <= z_next;
            end
        end
    end

    AST_IMM_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && src_is_imm) |-> (ctl.dir == SH_RIGHT)); // R1

    AST_EXT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        acc_out[AW-1:LW] == '0); // R5

    AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl.amt == '0) |=> (acc_out[LW-1:0] == $past(acc_in[LW-1:0]))); // R6

    AST_N_TRACKS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_n == acc_out[LW-1])); // R7

    AST_Z_TRACKS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flag_z == (acc_out[LW-1:0] == '0))); // R8

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(acc_out) && $stable(flag_n) && $stable(flag_z))); // R9
endmodule

// File: tb/tb_lsh_long_shifter.sv
module tb_lsh_long_shifter;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [35:0] acc_in;
    logic [15:0] src_in;
    logic        src_is_imm;
    logic        out_valid;
    logic [35:0] acc_out;
    logic        flag_n;
    logic        flag_z;

    always #10 clk = ~clk;

    lsh_long_shifter dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .acc_in     (acc_in),
        .src_in     (src_in),
        .src_is_imm (src_is_imm),
        .out_valid  (out_valid),
        .acc_out    (acc_out),
        .flag_n     (flag_n),
        .flag_z     (flag_z)
    );

    typedef struct {
        logic [35:0] acc;
        logic        n;
        logic        z;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   compared   = 0;
    int   mismatched = 0;

    function automatic exp_t model(input logic [35:0] a, input logic [15:0] s,
                                   input logic imm, input string tag);
        exp_t        e;
        logic [31:0] w;
        logic [15:0] mag;
        w = a[31:0];
        if (imm || !s[15]) begin
            w = w >> s[4:0];
        end else begin
            mag = 16'(0) - s;
            w   = w << mag[4:0];
        end
        e.acc = {4'h0, w};
        e.n   = w[31];
        e.z   = (w == 32'h0);
        e.tag = tag;
        return e;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [37:0] got, input logic [37:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [35:0] a, input logic [15:0] s,
                         input logic imm, input string tag);
        @(negedge clk);
        in_valid   = 1'b1;
        acc_in     = a;
        src_in     = s;
        src_is_imm = imm;
        sb.push_back(model(a, s, imm, tag));
    endtask

    task automatic go_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected out_valid", {acc_out, flag_n, flag_z}, 38'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({acc_out, flag_n, flag_z} == {e.acc, e.n, e.z}, e.tag,
                      {acc_out, flag_n, flag_z}, {e.acc, e.n, e.z});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog R9: run did not finish, got 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] x;
        rst = 1'b1; in_valid = 1'b0; acc_in = '0; src_in = '0; src_is_imm = 1'b0;
        repeat (3) @(negedge clk);
        // R10: state after reset
        check({out_valid, acc_out, flag_n, flag_z} == 39'h0, "R10 reset state",
              {acc_out, flag_n, flag_z}, 38'h0);
        rst = 1'b0;

        drive(36'hF_F123_3456, 16'h0010, 1'b0, "R2 worked case count 16");
        drive(36'hF_F123_3456, 16'h7FE3, 1'b0, "R2 junk in bits 14..5");
        drive(36'hF_F123_3456, 16'h0010, 1'b1, "R1 immediate 16");
        drive(36'h0_8765_4321, 16'h8004, 1'b1, "R1 immediate ignores bit 15");
        drive(36'h0_F123_3456, 16'hFFFC, 1'b0, "R3 count -4");
        drive(36'h0_0000_0001, 16'hFFE1, 1'b0, "R3 R7 count -31 sets N");
        drive(36'h0_ABCD_1234, 16'hFFE0, 1'b0, "R3 count -32 shifts zero");
        drive(36'h0_ABCD_1234, 16'h8000, 1'b0, "R3 most negative count");
        drive(36'h0_4000_0001, 16'hFFFF, 1'b0, "R3 R7 count -1");
        drive(36'hA_0000_FFFF, 16'h0000, 1'b1, "R6 R5 immediate zero");
        drive(36'h5_8000_0000, 16'h0000, 1'b0, "R6 R5 R7 register zero");
        drive(36'hF_7FFF_FFFF, 16'h001F, 1'b0, "R4 R5 right 31");
        drive(36'h0_8000_0000, 16'hFFFF, 1'b0, "R8 left shift to zero");
        drive(36'h0_0000_0001, 16'h0001, 1'b1, "R8 right shift to zero");
        drive(36'hF_FFFF_FFFF, 16'hFFF0, 1'b0, "R4 left fill zeros");
        x = 32'h1234_5678;
        for (int i = 0; i < 120; i++) begin
            x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
            drive({x[3:0], x ^ 32'h9E37_79B9}, x[31:16], x[7], "R4 sweep");
        end

        drive(36'h5_8000_0001, 16'h0001, 1'b1, "R9 capture");
        go_idle(3);
        // R9: held while idle
        check(out_valid == 1'b0, "R9 out_valid low when idle",
              {37'h0, out_valid}, 38'h0);
        check({acc_out, flag_n, flag_z} == {36'h0_4000_0000, 1'b0, 1'b0}, "R9 hold while idle",
              {acc_out, flag_n, flag_z}, {36'h0_4000_0000, 1'b0, 1'b0});

        // R10: reset wins over the strobe
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; acc_in = 36'hF_FFFF_FFFF; src_in = 16'h0000; src_is_imm = 1'b1;
        @(negedge clk);
        check({out_valid, acc_out, flag_n, flag_z} == 39'h0, "R10 reset with strobe",
              {acc_out, flag_n, flag_z}, 38'h0);
        rst = 1'b0; in_valid = 1'b0;
        go_idle(2);
        check(sb.size() == 0, "R9 all results delivered", 38'(sb.size()), 38'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule